// File: doc/BRIEF.md
# Aspect-Signal Change Monitor

This block watches the aspect/blanking status lines of two video connectors. Each line has three meaningful voltage bands, and an analog comparator front end, outside this block, has already reduced it to a two-bit level code. The block filters each code so that short glitches are ignored. It presents the filtered levels in a status byte that the serial-bus slave returns on a read. When either filtered level changes, it raises a change interrupt on an open-drain pin, which is modelled here as an output-enable.

The interrupt is single-shot. Software arms it by writing the enable bit to 1. When a change is accepted, the block sets the flag and clears the enable bit. A status read clears the flag and releases the pin. Software then has to write the enable bit to 1 again before another interrupt can occur. Detection runs from the clock alone and has no power-down gating, so a level change can wake a host while the rest of the chip is in standby.

Top module: `aspect_signal_monitor`

## Requirements
- R1: After reset, the status byte reads 0x05 (both levels 01), the flag is 0, the enable is 0 and `irqOe` is 0.
- R2: The status byte holds connector A's level in bits 1:0 and connector B's level in bits 3:2. Bit 4 is the interrupt flag and bits 7:5 read 0. The level codes are 01 for the low band, 10 for the widescreen band and 11 for the standard-aspect band.
- R3: A new input code is accepted only after it has been held for 4 consecutive clocks. A code held for 3 clocks or fewer leaves the status byte unchanged and raises no interrupt.
- R4: A code driven just before rising edge 0 appears in the status byte, and sets the flag, right after rising edge 4.
- R5: When the enable is 1 and a change is accepted on either connector, the flag sets and `irqOe` goes to 1.
- R6: When the enable is 0, an accepted change updates the level fields but leaves the flag and `irqOe` at 0.
- R7: A one-cycle `statusRead` pulse clears the flag and `irqOe`.
- R8: Taking an interrupt clears the enable. Later changes raise no interrupt until the enable is written to 1 again.
- R9: Writing the enable to 0 disarms the interrupt, and a later change then sets no flag.
- R10: If a read and a newly accepted armed change fall on the same clock, the flag stays set.
- R11: If an enable write and an armed accepted change fall on the same clock, the flag sets and the enable takes the written value.
- R12: If the input moves to a second new code before the first one is accepted, the count restarts. Only the code that is then held for 4 clocks is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcLevelA | input | 2 | Quantized level code, connector A |
| srcLevelB | input | 2 | Quantized level code, connector B |
| irqArmWrite | input | 1 | One-cycle strobe that writes the enable bit |
| irqArmValue | input | 1 | Value written to the enable bit |
| statusRead | input | 1 | One-cycle strobe: the status byte is being read |
| statusByte | output | 8 | Filtered levels and interrupt flag |
| irqArmed | output | 1 | Current value of the enable bit |
| irqOe | output | 1 | Drive the open-drain interrupt pin low |

## Verification
The hardest situations to reach are the same-clock collisions. In one, the fourth stable clock of a new level lands on the exact edge that carries a read strobe. In the other, it lands on the edge that carries an enable write. The bench gets there by counting edges from the negative edge on which it drives the new code. It places the strobe on the negative edge just before accept edge 4, so the strobe is sampled together with the acceptance. The glitch and flicker cases use the same counting to hold a code for exactly 3 clocks, or to switch codes partway through the filter window.

// File: rtl/aspect_mon_pkg.sv
package aspect_mon_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_SRC = 2;
  localparam int STAT_W  = 8;
  localparam int FLAG_BIT = NUM_SRC * LVL_W;

  localparam logic [LVL_W-1:0] LVL_LOW    = 2'b01;
  localparam logic [LVL_W-1:0] LVL_WIDE   = 2'b10;
  localparam logic [LVL_W-1:0] LVL_NARROW = 2'b11;

  // strobes from the datapath to the control: one accept pulse per source
  typedef struct packed {
    logic [NUM_SRC-1:0] accepted;
  } monEvt_t;
endpackage

// File: rtl/aspect_mon_datapath.sv
module aspect_mon_datapath
  import aspect_mon_pkg::*;
#(
  parameter int STABLE_CYCLES = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC*LVL_W-1:0] levelsIn,
  output logic [NUM_SRC*LVL_W-1:0] levelsOut,
  output monEvt_t                  evt
);
  localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STABLE_CYCLES - 1);

  logic [NUM_SRC-1:0] hitVec;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic [LVL_W-1:0] sampledQ;
    logic [LVL_W-1:0] candQ;
    logic [LVL_W-1:0] stableQ;
    logic [CNT_W-1:0] runCnt;
    logic isNew;
    logic sameCand;
    logic hit;

    always_comb begin
      isNew    = (sampledQ != stableQ);
      sameCand = (sampledQ == candQ);
      hit      = isNew && sameCand && (runCnt == LAST_CNT);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sampledQ <= LVL_LOW;
        candQ    <= LVL_LOW;
        stableQ  <= LVL_LOW;
        runCnt   <= '0;
      end else begin
        sampledQ <= levelsIn[k*LVL_W +: LVL_W];
        if (!isNew) begin
          runCnt <= '0;
        end else if (!sameCand) begin
          candQ  <= sampledQ;
          runCnt <= CNT_W'(1);
        end else if (hit) begin
          stableQ <= sampledQ;
          runCnt  <= '0;
        end else begin
          runCnt <= runCnt + CNT_W'(1);
        end
      end
    end

    assign levelsOut[k*LVL_W +: LVL_W] = stableQ;
    assign hitVec[k] = hit;
  end

  assign evt.accepted = hitVec;
endmodule

// File: rtl/aspect_mon_control.sv
module aspect_mon_control
  import aspect_mon_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  monEvt_t evt,
  input  logic    armWrStb,
  input  logic    armWrData,
  input  logic    statusRd,
  output logic    armedQ,
  output logic    flagQ
);
  logic anyEvt;
  logic takeIrq;

  always_comb begin
    anyEvt  = |evt.accepted;
    takeIrq = armedQ && anyEvt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      flagQ  <= 1'b0;
    end else begin
      flagQ <= (flagQ && !statusRd) || takeIrq;
      if (armWrStb)     armedQ <= armWrData;
      else if (takeIrq) armedQ <= 1'b0;
    end
  end
endmodule

// File: rtl/aspect_signal_monitor.sv
module aspect_signal_monitor
  import aspect_mon_pkg::*;
#(
  parameter int STABLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LVL_W-1:0]  srcLevelA,
  input  logic [LVL_W-1:0]  srcLevelB,
  input  logic              irqArmWrite,
  input  logic              irqArmValue,
  input  logic              statusRead,
  output logic [STAT_W-1:0] statusByte,
  output logic              irqArmed,
  output logic              irqOe
);
  localparam int PAD_W = STAT_W - FLAG_BIT - 1;

  logic [NUM_SRC*LVL_W-1:0] levelsFilt;
  monEvt_t evtStb;
  logic flag;

  aspect_mon_datapath #(.STABLE_CYCLES(STABLE_CYCLES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .levelsIn  ({srcLevelB, srcLevelA}),
    .levelsOut (levelsFilt),
    .evt       (evtStb)
  );

  aspect_mon_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (evtStb),
    .armWrStb  (irqArmWrite),
    .armWrData (irqArmValue),
    .statusRd  (statusRead),
    .armedQ    (irqArmed),
    .flagQ     (flag)
  );

  assign statusByte = {{PAD_W{1'b0}}, flag, levelsFilt};
  assign irqOe      = flag;
endmodule

// File: rtl/aspect_signal_monitor_chk.sv
module aspect_signal_monitor_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] srcLevelA,
  input logic [1:0] srcLevelB,
  input logic       irqArmWrite,
  input logic       statusRead,
  input logic [7:0] statusByte,
  input logic       irqArmed,
  input logic       irqOe
);
  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |=> (statusByte == 8'h05 && !irqArmed && !irqOe));

  // R5: a rising interrupt needs the enable set on the edge before
  a_r5_flag_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOe) |-> $past(irqArmed));

  // R7: a read with nothing armed leaves the pin released
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !irqArmed) |=> !irqOe);

  // R8: taking an interrupt drops the enable unless it was rewritten
  a_r8_single_shot: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irqOe) && !$past(irqArmWrite)) |-> !irqArmed);

  // R3: a reported level for A was held over the whole default window
  a_r3_level_a_held: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusByte[1:0]) |->
      (statusByte[1:0] == $past(srcLevelA, 2) &&
       statusByte[1:0] == $past(srcLevelA, 3) &&
       statusByte[1:0] == $past(srcLevelA, 4) &&
       statusByte[1:0] == $past(srcLevelA, 5)));

  // R3: same for B
  a_r3_level_b_held: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusByte[3:2]) |->
      (statusByte[3:2] == $past(srcLevelB, 2) &&
       statusByte[3:2] == $past(srcLevelB, 3) &&
       statusByte[3:2] == $past(srcLevelB, 4) &&
       statusByte[3:2] == $past(srcLevelB, 5)));
endmodule

bind aspect_signal_monitor aspect_signal_monitor_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .srcLevelA   (srcLevelA),
  .srcLevelB   (srcLevelB),
  .irqArmWrite (irqArmWrite),
  .statusRead  (statusRead),
  .statusByte  (statusByte),
  .irqArmed    (irqArmed),
  .irqOe       (irqOe)
);

// File: tb/aspect_signal_monitor_test.sv
`timescale 1ns/1ps
module aspect_signal_monitor_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] srcLevelA = 2'b01;
  logic [1:0] srcLevelB = 2'b01;
  logic       irqArmWrite = 1'b0;
  logic       irqArmValue = 1'b0;
  logic       statusRead = 1'b0;
  logic [7:0] statusByte;
  logic       irqArmed;
  logic       irqOe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  aspect_signal_monitor uut (
    .clk(clk), .rstN(rstN), .srcLevelA(srcLevelA), .srcLevelB(srcLevelB),
    .irqArmWrite(irqArmWrite), .irqArmValue(irqArmValue),
    .statusRead(statusRead), .statusByte(statusByte),
    .irqArmed(irqArmed), .irqOe(irqOe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeArm(input logic v);
    irqArmWrite = 1'b1; irqArmValue = v;
    tick(1);
    irqArmWrite = 1'b0; irqArmValue = 1'b0;
  endtask

  task automatic readStatus();
    statusRead = 1'b1;
    tick(1);
    statusRead = 1'b0;
  endtask

  task automatic test_reset();
    chk("R1 status", statusByte, 8'h05);
    chk("R1 irqOe", {7'b0, irqOe}, 8'h00);
    chk("R1 armed", {7'b0, irqArmed}, 8'h00);
  endtask

  task automatic test_encoding();
    srcLevelA = 2'b10; tick(6);
    chk("R2 A wide", statusByte, 8'h06);
    srcLevelB = 2'b11; tick(6);
    chk("R2 B narrow", statusByte, 8'h0E);
    srcLevelA = 2'b11; tick(6);
    chk("R2 A narrow", statusByte, 8'h0F);
    chk("R6 unarmed no irq", {7'b0, irqOe}, 8'h00);
  endtask

  task automatic test_glitch();
    writeArm(1'b1);
    srcLevelA = 2'b01; tick(3);
    srcLevelA = 2'b11; tick(8);
    chk("R3 glitch status", statusByte, 8'h0F);
    chk("R3 glitch irqOe", {7'b0, irqOe}, 8'h00);
    chk("R3 glitch armed kept", {7'b0, irqArmed}, 8'h01);
  endtask

  task automatic test_latency();
    srcLevelB = 2'b10; tick(4);
    chk("R4 before edge 4", statusByte, 8'h0F);
    tick(1);
    chk("R4 after edge 4", statusByte, 8'h1B);
    chk("R5 irqOe set", {7'b0, irqOe}, 8'h01);
    chk("R8 armed cleared", {7'b0, irqArmed}, 8'h00);
  endtask

  task automatic test_read();
    readStatus();
    chk("R7 flag cleared", statusByte, 8'h0B);
    chk("R7 irqOe released", {7'b0, irqOe}, 8'h00);
  endtask

  task automatic test_single_shot();
    srcLevelA = 2'b10; tick(6);
    chk("R8 no rearm no irq", statusByte, 8'h0A);
    writeArm(1'b1);
    srcLevelA = 2'b01; tick(6);
    chk("R8 rearmed irq", statusByte, 8'h19);
    readStatus();
  endtask

  task automatic test_disarm();
    writeArm(1'b1);
    writeArm(1'b0);
    chk("R9 armed readback", {7'b0, irqArmed}, 8'h00);
    srcLevelB = 2'b11; tick(6);
    chk("R9 disarmed status", statusByte, 8'h0D);
    chk("R9 disarmed irqOe", {7'b0, irqOe}, 8'h00);
  endtask

  task automatic test_read_collision();
    writeArm(1'b1);
    srcLevelA = 2'b11; tick(6);
    chk("R10 setup flag", statusByte, 8'h1F);
    writeArm(1'b1);
    srcLevelA = 2'b10; tick(4);
    statusRead = 1'b1; tick(1); statusRead = 1'b0;
    chk("R10 flag survives read", statusByte, 8'h1E);
    chk("R10 irqOe", {7'b0, irqOe}, 8'h01);
    readStatus();
    chk("R10 cleared after", statusByte, 8'h0E);
  endtask

  task automatic test_write_collision();
    writeArm(1'b1);
    srcLevelB = 2'b10; tick(4);
    irqArmWrite = 1'b1; irqArmValue = 1'b1;
    tick(1);
    irqArmWrite = 1'b0; irqArmValue = 1'b0;
    chk("R11 flag set", statusByte, 8'h1A);
    chk("R11 armed keeps write", {7'b0, irqArmed}, 8'h01);
    readStatus();
    writeArm(1'b0);
  endtask

  task automatic test_flicker();
    srcLevelA = 2'b01; tick(2);
    srcLevelA = 2'b11; tick(4);
    chk("R12 restart not yet", statusByte, 8'h0A);
    tick(1);
    chk("R12 second code", statusByte, 8'h0B);
    chk("R12 unarmed irqOe", {7'b0, irqOe}, 8'h00);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    test_reset();
    test_encoding();
    test_glitch();
    test_latency();
    test_read();
    test_single_shot();
    test_disarm();
    test_read_collision();
    test_write_collision();
    test_flicker();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule